// File: doc/BRIEF.md
# PWM Register Update Synchronizer

This block decides when a PWM timer's buffered configuration values become its live values. Software writes five register groups into buffer copies over a simple write port: a software output-control word, an output-inversion word, an output mask, and a timing group made of the period, the initial count and one compare value per channel. A configuration word chooses, for each group, whether the software trigger, the hardware trigger or both can move the buffer into the active copy. It also chooses whether the event restarts the counter. The output-control and inversion words can instead track their buffers on every clock.

Two synchronization modes exist. In enhanced mode, a pending software trigger or a hardware trigger pulse transfers the selected output-side groups at once. The timing group is armed and lands at the next counter-boundary strobe. In legacy mode, only the software trigger counts, and everything it enables transfers together at a boundary strobe. The counter itself lives outside this block. It receives a one-cycle reload pulse when counter synchronization is enabled for the trigger that fired.

Top module: `pwm_sync_ctrl`

## Requirements
- R1: Only configuration bits 12..0 are stored. A write to address 0 sets `cfg_q` to `wr_data & 32'h1FFF`, and bits 31..13 always read 0. Bit map: 0 enhanced mode, 1 output-control sync select, 2 inversion sync select, 3..7 software enables for counter, timing group, mask, inversion and output control, 8..12 hardware enables for the same five in the same order.
- R2: With its sync-select bit at 0, `swoc_act` (buffer at address 1) and `inv_act` (buffer at address 2) each equal their buffer as it stood one clock earlier.
- R3: With bit 1 set, `swoc_act` changes only on a synchronization event whose trigger has the output-control enable set.
- R4: With bit 2 set, `inv_act` follows the same rule using its own enables. The mask (buffer at address 3) always waits for an enabled event.
- R5: A trigger whose enable bit for a group is 0 leaves that group's active copy unchanged and, for the counter, issues no reload pulse.
- R6: In enhanced mode, an enabled trigger arms the timing group (period at address 4, initial count at address 5, compares at 6 and up). The group is copied at the next clock edge that samples `boundary` high.
- R7: In legacy mode, `hw_trig` has no effect. A pending software trigger transfers its enabled groups, the timing group included, at the first edge that samples `boundary` high.
- R8: A `sw_trig` pulse sets `sw_pend` at the next edge. The bit clears at the edge where its synchronization is carried out: the next edge in enhanced mode, a boundary edge in legacy mode. It stays set if `sw_trig` is high again at that edge.
- R9: `cnt_reload` is high for exactly the cycle after an event whose trigger has the counter enable set.
- R10: A software and a hardware trigger served at the same edge form one event that transfers the union of their enabled groups and gives at most one reload pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| sw_trig | input | 1 | Software trigger pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| boundary | input | 1 | Counter boundary strobe |
| cfg_q | output | 32 | Configuration word readback |
| sw_pend | output | 1 | Software trigger pending bit |
| swoc_act | output | NCH | Active software output-control word |
| inv_act | output | NCH/2 | Active inversion word, one bit per channel pair |
| mask_act | output | NCH | Active output mask |
| period_act | output | DW | Active period |
| init_act | output | DW | Active initial count |
| cmp_act | output | NCH*DW | Active compare values, channel 0 in low bits |
| cnt_reload | output | 1 | Counter reload pulse |

## Verification
The functions that can collide are the software-trigger service and a hardware trigger pulse. They meet at the edge where a pending software request is served while `hw_trig` is high. The bench provokes this on purpose. It raises `hw_trig` exactly one cycle after `sw_trig`, with different groups enabled for each trigger. It then checks that both groups move at that same edge and that only one reload pulse appears. Random traffic also lands triggers on boundary strobes and on buffer writes. A cycle model built from the requirements judges each case.

// File: rtl/pwm_sync_pkg.sv
// Shared types for the PWM register update synchronizer.
// Assumes the configuration field order below; the bench relies on it.
package pwm_sync_pkg;
    localparam int CFG_BITS  = 13;
    localparam int ADDR_CFG  = 0;
    localparam int ADDR_SWOC = 1;
    localparam int ADDR_INV  = 2;
    localparam int ADDR_MASK = 3;
    localparam int ADDR_PER  = 4;
    localparam int ADDR_INIT = 5;
    localparam int ADDR_CMP0 = 6;

    // Stored configuration word, enh is bit 0, hw_swoc is bit 12.
    typedef struct packed {
        logic hw_swoc;
        logic hw_inv;
        logic hw_mask;
        logic hw_per;
        logic hw_cnt;
        logic sw_swoc;
        logic sw_inv;
        logic sw_mask;
        logic sw_per;
        logic sw_cnt;
        logic inv_sel;
        logic swoc_sel;
        logic enh;
    } sync_cfg_t;
endpackage

// File: rtl/pwm_sync_regs.sv
// Configuration word and buffer registers written over the bus port.
// Assumes DW <= 32; writes to unmapped addresses are dropped.
module pwm_sync_regs
    import pwm_sync_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [31:0]         wr_data,
    output sync_cfg_t           cfg,
    output logic [NCH-1:0]      swoc_buf,
    output logic [NCH/2-1:0]    inv_buf,
    output logic [NCH-1:0]      mask_buf,
    output logic [DW-1:0]       per_buf,
    output logic [DW-1:0]       init_buf,
    output logic [NCH*DW-1:0]   cmp_buf
);
    // Store the configuration word, keeping only the defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en && wr_addr == AW'(ADDR_CFG))
            cfg <= sync_cfg_t'(wr_data[CFG_BITS-1:0]);
    end

    // Capture writes into the output-side buffers and the timing buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swoc_buf <= '0;
            inv_buf  <= '0;
            mask_buf <= '0;
            per_buf  <= '0;
            init_buf <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_SWOC)) swoc_buf <= wr_data[NCH-1:0];
            if (wr_addr == AW'(ADDR_INV))  inv_buf  <= wr_data[NCH/2-1:0];
            if (wr_addr == AW'(ADDR_MASK)) mask_buf <= wr_data[NCH-1:0];
            if (wr_addr == AW'(ADDR_PER))  per_buf  <= wr_data[DW-1:0];
            if (wr_addr == AW'(ADDR_INIT)) init_buf <= wr_data[DW-1:0];
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        // Capture a write to compare buffer k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_buf[k*DW +: DW] <= '0;
            else if (wr_en && wr_addr == AW'(ADDR_CMP0 + k))
                cmp_buf[k*DW +: DW] <= wr_data[DW-1:0];
        end
    end

    // R1
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_CFG)) |=> (cfg == sync_cfg_t'($past(wr_data[CFG_BITS-1:0]))));
endmodule

// File: rtl/pwm_sync_event.sv
// Decides, each clock, which register groups transfer and whether the
// counter reloads. Holds the software trigger pending bit and the armed
// timing-group request. hw_trig and boundary are single-cycle strobes.
module pwm_sync_event
    import pwm_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sync_cfg_t cfg,
    input  logic      sw_trig,
    input  logic      hw_trig,
    input  logic      boundary,
    output logic      load_swoc,
    output logic      load_inv,
    output logic      load_mask,
    output logic      load_per,
    output logic      sw_pend_q,
    output logic      cnt_reload_q
);
    logic per_arm_q;
    logic per_arm_d;
    logic reload_d;
    logic sw_served;
    logic fire_leg;

    // Form the group loads for the selected synchronization mode.
    always_comb begin
        fire_leg = sw_pend_q && boundary;
        if (cfg.enh) begin
            load_swoc = (sw_pend_q && cfg.sw_swoc) || (hw_trig && cfg.hw_swoc);
            load_inv  = (sw_pend_q && cfg.sw_inv)  || (hw_trig && cfg.hw_inv);
            load_mask = (sw_pend_q && cfg.sw_mask) || (hw_trig && cfg.hw_mask);
            reload_d  = (sw_pend_q && cfg.sw_cnt)  || (hw_trig && cfg.hw_cnt);
            load_per  = per_arm_q && boundary;
            per_arm_d = (sw_pend_q && cfg.sw_per) || (hw_trig && cfg.hw_per)
                        || (per_arm_q && !boundary);
            sw_served = sw_pend_q;
        end else begin
            load_swoc = fire_leg && cfg.sw_swoc;
            load_inv  = fire_leg && cfg.sw_inv;
            load_mask = fire_leg && cfg.sw_mask;
            reload_d  = fire_leg && cfg.sw_cnt;
            load_per  = fire_leg && cfg.sw_per;
            per_arm_d = 1'b0;
            sw_served = fire_leg;
        end
    end

    // Track the software trigger, the armed timing request and the reload pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend_q    <= 1'b0;
            per_arm_q    <= 1'b0;
            cnt_reload_q <= 1'b0;
        end else begin
            sw_pend_q    <= sw_trig || (sw_pend_q && !sw_served);
            per_arm_q    <= per_arm_d;
            cnt_reload_q <= reload_d;
        end
    end

    // R8
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend_q && cfg.enh && !sw_trig) |=> !sw_pend_q);
    // R7
    legacy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.enh && !boundary) |=> !cnt_reload_q);
    // R5
    no_trig_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.enh && !sw_pend_q && !hw_trig) |=> !cnt_reload_q);
endmodule

// File: rtl/pwm_sync_shadow.sv
// One active register copied from its buffer. It copies on every clock
// while follow is high, otherwise only when load is high.
module pwm_sync_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         follow,
    input  logic         load,
    input  logic [W-1:0] buf_d,
    output logic [W-1:0] act_q
);
    // Copy the buffer into the active register when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (follow || load)
            act_q <= buf_d;
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow && !load) |=> $stable(act_q));
    // R2
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        follow |=> (act_q == $past(buf_d)));
endmodule

// File: rtl/pwm_sync_ctrl.sv
// Top of the PWM register update synchronizer. It joins the register
// file, the event logic and one shadow per active register.
// Assumes NCH is even (inversion works on channel pairs) and DW <= 32.
module pwm_sync_ctrl
    import pwm_sync_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int AW = $clog2(ADDR_CMP0 + NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              sw_trig,
    input  logic              hw_trig,
    input  logic              boundary,
    output logic [31:0]       cfg_q,
    output logic              sw_pend,
    output logic [NCH-1:0]    swoc_act,
    output logic [NCH/2-1:0]  inv_act,
    output logic [NCH-1:0]    mask_act,
    output logic [DW-1:0]     period_act,
    output logic [DW-1:0]     init_act,
    output logic [NCH*DW-1:0] cmp_act,
    output logic              cnt_reload
);
    sync_cfg_t           cfg;
    logic [NCH-1:0]      swoc_buf;
    logic [NCH/2-1:0]    inv_buf;
    logic [NCH-1:0]      mask_buf;
    logic [DW-1:0]       per_buf;
    logic [DW-1:0]       init_buf;
    logic [NCH*DW-1:0]   cmp_buf;
    logic                load_swoc;
    logic                load_inv;
    logic                load_mask;
    logic                load_per;

    pwm_sync_regs #(.NCH(NCH), .DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .swoc_buf(swoc_buf), .inv_buf(inv_buf),
        .mask_buf(mask_buf), .per_buf(per_buf), .init_buf(init_buf),
        .cmp_buf(cmp_buf)
    );

    pwm_sync_event event_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .sw_trig(sw_trig),
        .hw_trig(hw_trig), .boundary(boundary), .load_swoc(load_swoc),
        .load_inv(load_inv), .load_mask(load_mask), .load_per(load_per),
        .sw_pend_q(sw_pend), .cnt_reload_q(cnt_reload)
    );

    pwm_sync_shadow #(.W(NCH)) swoc_i (
        .clk(clk), .rst_n(rst_n), .follow(!cfg.swoc_sel), .load(load_swoc),
        .buf_d(swoc_buf), .act_q(swoc_act)
    );

    pwm_sync_shadow #(.W(NCH/2)) inv_i (
        .clk(clk), .rst_n(rst_n), .follow(!cfg.inv_sel), .load(load_inv),
        .buf_d(inv_buf), .act_q(inv_act)
    );

    pwm_sync_shadow #(.W(NCH)) mask_i (
        .clk(clk), .rst_n(rst_n), .follow(1'b0), .load(load_mask),
        .buf_d(mask_buf), .act_q(mask_act)
    );

    pwm_sync_shadow #(.W(DW)) per_i (
        .clk(clk), .rst_n(rst_n), .follow(1'b0), .load(load_per),
        .buf_d(per_buf), .act_q(period_act)
    );

    pwm_sync_shadow #(.W(DW)) init_i (
        .clk(clk), .rst_n(rst_n), .follow(1'b0), .load(load_per),
        .buf_d(init_buf), .act_q(init_act)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        pwm_sync_shadow #(.W(DW)) cmp_i (
            .clk(clk), .rst_n(rst_n), .follow(1'b0), .load(load_per),
            .buf_d(cmp_buf[k*DW +: DW]), .act_q(cmp_act[k*DW +: DW])
        );
    end

    // Widen the stored configuration for readback; the upper bits stay zero.
    always_comb cfg_q = {{(32-CFG_BITS){1'b0}}, cfg};

    // R6
    per_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.enh && !boundary) |=> $stable(period_act));
    // R7
    legacy_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.enh && !sw_pend) |=> ($stable(mask_act) && !cnt_reload));
endmodule

// File: tb/pwm_sync_ctrl_tb.sv
// Bench for pwm_sync_ctrl: directed corner cases, then seeded random
// traffic, judged against a cycle model built from the requirements.
module pwm_sync_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int AW  = 4;
    localparam int CMAX = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              sw_trig = 1'b0;
    logic              hw_trig = 1'b0;
    logic              boundary = 1'b0;
    logic [31:0]       cfg_q;
    logic              sw_pend;
    logic [NCH-1:0]    swoc_act;
    logic [NCH/2-1:0]  inv_act;
    logic [NCH-1:0]    mask_act;
    logic [DW-1:0]     period_act;
    logic [DW-1:0]     init_act;
    logic [NCH*DW-1:0] cmp_act;
    logic              cnt_reload;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_sync_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sw_trig(sw_trig), .hw_trig(hw_trig),
        .boundary(boundary), .cfg_q(cfg_q), .sw_pend(sw_pend),
        .swoc_act(swoc_act), .inv_act(inv_act), .mask_act(mask_act),
        .period_act(period_act), .init_act(init_act), .cmp_act(cmp_act),
        .cnt_reload(cnt_reload)
    );

    // Reference model state.
    logic [12:0]       m_cfg;
    logic [NCH-1:0]    b_swoc, m_swoc;
    logic [NCH/2-1:0]  b_inv, m_inv;
    logic [NCH-1:0]    b_mask, m_mask;
    logic [DW-1:0]     b_per, m_per, b_init, m_init;
    logic [NCH*DW-1:0] b_cmp, m_cmp;
    logic              m_swp, m_arm, m_rel;

    function automatic logic grp(input logic s, input logic h,
                                 input logic se, input logic he);
        return (s && se) || (h && he);
    endfunction

    // Cycle model of the requirements, advanced on every rising edge.
    always @(posedge clk) begin
        logic ls, li, lm, lc, lp, na, srv, f;
        cyc++;
        if (!rst_n) begin
            m_cfg = '0; b_swoc = '0; m_swoc = '0; b_inv = '0; m_inv = '0;
            b_mask = '0; m_mask = '0; b_per = '0; m_per = '0; b_init = '0;
            m_init = '0; b_cmp = '0; m_cmp = '0; m_swp = 0; m_arm = 0; m_rel = 0;
        end else begin
            if (m_cfg[0]) begin
                ls = grp(m_swp, hw_trig, m_cfg[7], m_cfg[12]);
                li = grp(m_swp, hw_trig, m_cfg[6], m_cfg[11]);
                lm = grp(m_swp, hw_trig, m_cfg[5], m_cfg[10]);
                lc = grp(m_swp, hw_trig, m_cfg[3], m_cfg[8]);
                na = grp(m_swp, hw_trig, m_cfg[4], m_cfg[9]) || (m_arm && !boundary);
                lp = m_arm && boundary;
                srv = m_swp;
            end else begin
                f = m_swp && boundary;
                ls = f && m_cfg[7]; li = f && m_cfg[6]; lm = f && m_cfg[5];
                lc = f && m_cfg[3]; lp = f && m_cfg[4]; na = 0; srv = f;
            end
            if (!m_cfg[1] || ls) m_swoc = b_swoc;
            if (!m_cfg[2] || li) m_inv = b_inv;
            if (lm) m_mask = b_mask;
            if (lp) begin m_per = b_per; m_init = b_init; m_cmp = b_cmp; end
            m_rel = lc;
            m_arm = na;
            m_swp = sw_trig || (m_swp && !srv);
            if (wr_en) begin
                case (int'(wr_addr))
                    0: m_cfg = wr_data[12:0];
                    1: b_swoc = wr_data[NCH-1:0];
                    2: b_inv = wr_data[NCH/2-1:0];
                    3: b_mask = wr_data[NCH-1:0];
                    4: b_per = wr_data[DW-1:0];
                    5: b_init = wr_data[DW-1:0];
                    default: if (int'(wr_addr) >= 6 && int'(wr_addr) < 6 + NCH)
                        b_cmp[(int'(wr_addr)-6)*DW +: DW] = wr_data[DW-1:0];
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " cfg"},    64'(cfg_q), {51'd0, m_cfg});
        chk({req, " pend"},   64'(sw_pend), 64'(m_swp));
        chk({req, " swoc"},   64'(swoc_act), 64'(m_swoc));
        chk({req, " inv"},    64'(inv_act), 64'(m_inv));
        chk({req, " mask"},   64'(mask_act), 64'(m_mask));
        chk({req, " per"},    64'(period_act), 64'(m_per));
        chk({req, " init"},   64'(init_act), 64'(m_init));
        chk({req, " cmp"},    64'(cmp_act), 64'(m_cmp));
        chk({req, " reload"}, 64'(cnt_reload), 64'(m_rel));
    endtask

    task automatic step(input string req);
        @(posedge clk);
        @(negedge clk);
        chk_all(req);
        wr_en = 0; sw_trig = 0; hw_trig = 0; boundary = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string req);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
        step(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (CMAX) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("reset");
        chk("R1 reset cfg", 64'(cfg_q), 64'd0);
        chk("R9 reset reload", 64'(cnt_reload), 64'd0);

        // R1: reserved bits dropped
        wr(0, 32'hFFFF_FFFF, "R1");
        chk("R1 cfg mask", 64'(cfg_q), 64'h1FFF);

        // R2: follow mode for output control and inversion
        wr(0, 32'h0000_0001, "R2");
        wr(1, 32'h5, "R2");
        wr(2, 32'h2, "R2");
        step("R2");
        chk("R2 swoc follow", 64'(swoc_act), 64'h5);
        chk("R2 inv follow", 64'(inv_act), 64'h2);

        // R3/R4/R5: sync-select set, software enable only for output control
        wr(0, 32'h0000_0087, "R3");
        wr(1, 32'hA, "R3");
        wr(2, 32'h1, "R4");
        wr(3, 32'hF, "R5");
        step("R3");
        chk("R3 swoc held", 64'(swoc_act), 64'h5);
        sw_trig = 1; step("R8");
        chk("R8 pend set", 64'(sw_pend), 64'd1);
        step("R3");
        chk("R3 swoc loaded", 64'(swoc_act), 64'hA);
        chk("R4 inv held", 64'(inv_act), 64'h2);
        chk("R5 mask held", 64'(mask_act), 64'h0);
        chk("R8 pend clear", 64'(sw_pend), 64'd0);

        // R6: enhanced timing group waits for the boundary
        wr(4, 32'h1234, "R6");
        wr(0, 32'h0000_0211, "R6");
        hw_trig = 1; step("R6");
        step("R6");
        chk("R6 per not yet", 64'(period_act), 64'h0);
        boundary = 1; step("R6");
        chk("R6 per at boundary", 64'(period_act), 64'h1234);

        // R7: legacy mode ignores hw, software waits for boundary
        wr(0, 32'h0000_1F38, "R7");
        wr(3, 32'h6, "R7");
        hw_trig = 1; step("R7");
        chk("R7 hw ignored", 64'(mask_act), 64'h0);
        sw_trig = 1; step("R7");
        step("R7");
        chk("R7 waits boundary", 64'(mask_act), 64'h0);
        boundary = 1; step("R7");
        chk("R7 mask at boundary", 64'(mask_act), 64'h6);
        chk("R9 legacy reload", 64'(cnt_reload), 64'd1);
        step("R9");
        chk("R9 one cycle", 64'(cnt_reload), 64'd0);

        // R10: sw service and hw pulse on the same edge, different groups
        wr(0, 32'h0000_0587, "R10");
        wr(1, 32'h3, "R10");
        wr(3, 32'h9, "R10");
        sw_trig = 1; step("R10");
        hw_trig = 1; step("R10");
        chk("R10 swoc", 64'(swoc_act), 64'h3);
        chk("R10 mask", 64'(mask_act), 64'h9);
        chk("R10 reload", 64'(cnt_reload), 64'd1);
        step("R10");
        chk("R10 single pulse", 64'(cnt_reload), 64'd0);

        // R5: hardware counter enable clear, no reload from hw
        wr(0, 32'h0000_0001, "R5");
        hw_trig = 1; step("R5");
        chk("R5 no reload", 64'(cnt_reload), 64'd0);

        // Seeded random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            wr_en    = ($urandom % 4) == 0;
            wr_addr  = AW'($urandom % 12);
            wr_data  = $urandom;
            sw_trig  = ($urandom % 8) == 0;
            hw_trig  = ($urandom % 6) == 0;
            boundary = ($urandom % 5) == 0;
            step("R1-model R2 R3 R4 R6 R7 R8 R9 R10 random");
        end
        finish_run();
    end
endmodule